// File: doc/BRIEF.md
# Double-Buffered 8-bit PWM Generator

This block produces one pulse-width-modulated output from an 8-bit counter. The counter runs in one of two shapes. In wrap mode it counts 0 to 255 and then starts again at 0. In triangle mode it climbs from 0 to 255 and then falls back to 0. A clock-enable input, driven by an external prescaler, paces the counter. The duty value is compared against the count to decide when the output toggles.

Software writes the duty value into a holding register. That register always reads back the most recent write. The comparator works from a second, active register, and this register copies the holding value only when the counter sits at 255 during an enabled tick. That moment is the wrap point in wrap mode and the apex in triangle mode. Because the copy happens only there, a duty change cannot cut a pulse short or add a stray edge partway through a period.

A 2-bit polarity field controls the output. It can disconnect the output, select normal polarity or select inverted polarity. It also fixes the output level when the duty value is at either end of its range.

Top module: `pwm8_dbuf`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the counter, the holding register, the active register and the output. Afterwards `rd_data` reads 0 and `pwm_out` is 0.
- R2: One clock after a write (`wr_en` high), `rd_data` shows the written byte. This holds whether or not that value has reached the comparator yet.
- R3: The active compare value copies the holding value only on a clock where `tick` is high and the count is 255. A write made in the middle of a period leaves the rest of that period's pulse unchanged.
- R4: The counter and the output change only on clocks where `tick` is high. While `tick` is low the output holds its level.
- R5: Wrap mode (`fast_mode`=1) counts 0..255 and then returns to 0, for a period of 256 ticks. With `pol_sel`=2'b10 the output goes high on the wrap and low on a compare match. For duty C<255 it is high for C+1 ticks of each period.
- R6: Wrap mode with `pol_sel`=2'b11 is the inverse of R5. For C<255 the output is high for 255-C ticks of each period.
- R7: In wrap mode, C=255 fixes the output: always high with 2'b10 and always low with 2'b11. C=0 gets no special treatment and follows R5/R6 (1 or 255 high ticks).
- R8: Triangle mode (`fast_mode`=0) counts 0,1..255,254..1 and repeats, for a period of 510 ticks. With 2'b10 the output goes low on a match while rising and high on a match while falling. It is high for 2C ticks of each period.
- R9: Triangle mode with `pol_sel`=2'b11 is the inverse of R8. The output is high for 510-2C ticks of each period.
- R10: In triangle mode, C=0 and C=255 drive a fixed level at their match. The levels are: 2'b10 gives low for 0 and high for 255, and 2'b11 gives high for 0 and low for 255.
- R11: With `pol_sel[1]`=0 (codes 2'b00 and 2'b01) the output is disconnected and held low from the next clock onwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Counter enable from the prescaler |
| fast_mode | input | 1 | 1 selects wrap mode, 0 selects triangle mode |
| pol_sel | input | 2 | 0x: output off, 10: normal polarity, 11: inverted polarity |
| wr_en | input | 1 | Write strobe for the duty value |
| wr_data | input | 8 | Duty value to write |
| rd_data | output | 8 | Holding register read-back |
| pwm_out | output | 1 | PWM output |

## Verification
The output's high time is counted over a whole period for several duty values in each mode and polarity. This separates three possible errors: a wrong counter shape (256 against 510 ticks), a wrong match action, and an inverted polarity. Both duty extremes are driven in both modes, because 0 is fixed in triangle mode but not in wrap mode. A write made during a high pulse checks that the current pulse keeps its old length while read-back already shows the new value. Holding `tick` low during a pulse checks that the pulse is stretched by exactly the number of missing ticks.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;
  localparam int PWM_W_DEF = 8;

  typedef enum logic [1:0] {
    POL_OFF_A = 2'b00,
    POL_OFF_B = 2'b01,
    POL_NORM  = 2'b10,
    POL_INV   = 2'b11
  } pol_e;
endpackage

// File: rtl/pwm8_ramp.sv
module pwm8_ramp #(
  parameter int W = pwm8_pkg::PWM_W_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         fast_mode,
  output logic [W-1:0] cnt,
  output logic         falling,
  output logic         latch_pt
);
  localparam logic [W-1:0] TOP    = {W{1'b1}};
  localparam logic [W-1:0] TOP_M1 = TOP - 1'b1;
  localparam logic [W-1:0] ONE    = {{(W-1){1'b0}}, 1'b1};

  function automatic logic [W-1:0] next_count(input logic fast, input logic dn,
                                               input logic [W-1:0] c);
    if (fast)           return c + 1'b1;
    if (!dn && c == TOP) return TOP_M1;
    if (dn && c == '0)   return ONE;
    return dn ? c - 1'b1 : c + 1'b1;
  endfunction

  function automatic logic next_dir(input logic fast, input logic dn,
                                    input logic [W-1:0] c);
    if (fast)            return 1'b0;
    if (!dn && c == TOP) return 1'b1;
    if (dn && c == '0)   return 1'b0;
    return dn;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      falling <= 1'b0;
    end else if (tick) begin
      cnt     <= next_count(fast_mode, falling, cnt);
      falling <= next_dir(fast_mode, falling, cnt);
    end
  end

  assign latch_pt = tick && (cnt == TOP);

  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));  // R4
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    (tick && fast_mode && cnt == TOP) |=> (cnt == '0));  // R5
  AST_APEX_TURN: assert property (@(posedge clk) disable iff (rst)
    (tick && !fast_mode && !falling && cnt == TOP) |=> (cnt == TOP_M1 && falling));  // R8
  AST_FAST_RISING: assert property (@(posedge clk) disable iff (rst)
    fast_mode |-> !falling);  // R5
endmodule

// File: rtl/pwm8_cmpbuf.sv
module pwm8_cmpbuf #(
  parameter int W = pwm8_pkg::PWM_W_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         latch_pt,
  output logic [W-1:0] hold_val,
  output logic [W-1:0] active_val
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_val   <= '0;
      active_val <= '0;
    end else begin
      if (wr_en)    hold_val   <= wr_data;
      if (latch_pt) active_val <= hold_val;
    end
  end

  AST_ACTIVE_ONLY_AT_LATCH: assert property (@(posedge clk) disable iff (rst)
    !latch_pt |=> $stable(active_val));  // R3
  AST_HOLD_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(hold_val));  // R2
endmodule

// File: rtl/pwm8_wave.sv
module pwm8_wave #(
  parameter int W = pwm8_pkg::PWM_W_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         fast_mode,
  input  logic [1:0]   pol_sel,
  input  logic [W-1:0] cnt,
  input  logic         falling,
  input  logic [W-1:0] active_val,
  output logic         wave
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  function automatic logic next_level(input logic fast, input logic dn,
                                      input logic [W-1:0] c, input logic [W-1:0] a,
                                      input logic inv, input logic cur);
    if (fast) begin
      if (c == TOP) return ~inv;
      if (c == a)   return inv;
      return cur;
    end
    if (c != a)   return cur;
    if (a == '0)  return inv;
    if (a == TOP) return ~inv;
    return dn ? ~inv : inv;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)             wave <= 1'b0;
    else if (!pol_sel[1]) wave <= 1'b0;
    else if (tick)       wave <= next_level(fast_mode, falling, cnt, active_val,
                                            pol_sel[0], wave);
  end

  AST_OFF_IS_LOW: assert property (@(posedge clk) disable iff (rst)
    !pol_sel[1] |=> !wave);  // R11
  AST_WAVE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!tick && pol_sel[1]) |=> $stable(wave));  // R4
endmodule

// File: rtl/pwm8_dbuf.sv
module pwm8_dbuf #(
  parameter int W = pwm8_pkg::PWM_W_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         fast_mode,
  input  logic [1:0]   pol_sel,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  output logic         pwm_out
);
  localparam logic [W-1:0] TOP    = {W{1'b1}};
  localparam logic [W-1:0] TOP_M1 = TOP - 1'b1;

  logic [W-1:0] cnt;
  logic         falling;
  logic         latch_pt;
  logic [W-1:0] active_val;

  pwm8_ramp #(.W(W)) u_ramp (
    .clk(clk), .rst(rst), .tick(tick), .fast_mode(fast_mode),
    .cnt(cnt), .falling(falling), .latch_pt(latch_pt)
  );

  pwm8_cmpbuf #(.W(W)) u_buf (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .latch_pt(latch_pt), .hold_val(rd_data), .active_val(active_val)
  );

  pwm8_wave #(.W(W)) u_wave (
    .clk(clk), .rst(rst), .tick(tick), .fast_mode(fast_mode),
    .pol_sel(pol_sel), .cnt(cnt), .falling(falling),
    .active_val(active_val), .wave(pwm_out)
  );

  AST_LATCH_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    ($changed(active_val) && !$past(rst)) |->
      (fast_mode ? (cnt == '0) : (cnt == TOP_M1)));  // R3
  AST_RD_LAST_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (rd_data == $past(wr_data)));  // R2
endmodule

// File: tb/pwm8_dbuf_bench.sv
module pwm8_dbuf_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b1;
  logic       fast_mode = 1'b1;
  logic [1:0] pol_sel = 2'b10;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       pwm_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwm8_dbuf u_pwm8_dbuf (
    .clk(clk), .rst(rst), .tick(tick), .fast_mode(fast_mode),
    .pol_sel(pol_sel), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pwm_out(pwm_out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; tick = 1'b1; wr_en = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic write_duty(input logic [7:0] v);
    wr_data = v; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic high_count(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
  endtask

  task automatic wait_rise();
    logic prev;
    prev = pwm_out;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!prev && pwm_out) return;
      prev = pwm_out;
    end
  endtask

  task automatic duty_case(input string req, input bit fast, input logic [1:0] pol,
                           input logic [7:0] c, input int exp);
    int hi;
    int per;
    per = fast ? 256 : 510;
    do_reset();
    fast_mode = fast; pol_sel = pol;
    write_duty(c);
    repeat (fast ? 600 : 1100) @(negedge clk);
    high_count(per, hi);
    check(req, hi, exp);
  endtask

  task automatic t_reset();
    int hi;
    do_reset();
    fast_mode = 1'b1; pol_sel = 2'b10;
    write_duty(8'hA7);
    repeat (600) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 rd_data after reset", rd_data, 0);
    check("R1 pwm_out after reset", pwm_out, 0);
    pol_sel = 2'b11;
    repeat (300) @(negedge clk);
    high_count(256, hi);
    check("R1 active cleared (inverted high of 256)", hi, 255);
  endtask

  task automatic t_readback();
    do_reset();
    tick = 1'b0;
    write_duty(8'h5A);
    check("R2 readback first write", rd_data, 8'h5A);
    write_duty(8'hC3);
    check("R2 readback latest write", rd_data, 8'hC3);
    tick = 1'b1;
  endtask

  task automatic t_midwrite();
    int n;
    do_reset();
    fast_mode = 1'b1; pol_sel = 2'b10;
    write_duty(8'd100);
    repeat (600) @(negedge clk);
    wait_rise();
    n = 1;
    wr_data = 8'd200; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (pwm_out) n++;
    check("R2 readback before latch", rd_data, 200);
    while (pwm_out && n < 1000) begin
      @(negedge clk);
      if (pwm_out) n++;
    end
    check("R3 current pulse unchanged", n, 101);
    wait_rise();
    n = 1;
    while (n < 1000) begin
      @(negedge clk);
      if (!pwm_out) break;
      n++;
    end
    check("R3 next pulse uses new value", n, 201);
  endtask

  task automatic t_tick_hold();
    int n;
    int stuck;
    do_reset();
    fast_mode = 1'b1; pol_sel = 2'b10;
    write_duty(8'd100);
    repeat (600) @(negedge clk);
    wait_rise();
    n = 1; stuck = 0;
    tick = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pwm_out) begin n++; stuck++; end
    end
    tick = 1'b1;
    check("R4 output held while tick low", stuck, 20);
    while (n < 1000) begin
      @(negedge clk);
      if (!pwm_out) break;
      n++;
    end
    check("R4 pulse stretched by idle ticks", n, 121);
  endtask

  task automatic t_fast_norm();
    duty_case("R5 wrap normal C=100", 1'b1, 2'b10, 8'd100, 101);
    duty_case("R5 wrap normal C=17",  1'b1, 2'b10, 8'd17,  18);
    duty_case("R5 wrap normal C=254", 1'b1, 2'b10, 8'd254, 255);
  endtask

  task automatic t_fast_inv();
    duty_case("R6 wrap inverted C=100", 1'b1, 2'b11, 8'd100, 155);
    duty_case("R6 wrap inverted C=200", 1'b1, 2'b11, 8'd200, 55);
  endtask

  task automatic t_fast_ext();
    duty_case("R7 wrap normal C=255",   1'b1, 2'b10, 8'd255, 256);
    duty_case("R7 wrap inverted C=255", 1'b1, 2'b11, 8'd255, 0);
    duty_case("R7 wrap normal C=0",     1'b1, 2'b10, 8'd0,   1);
    duty_case("R7 wrap inverted C=0",   1'b1, 2'b11, 8'd0,   255);
  endtask

  task automatic t_tri_norm();
    duty_case("R8 triangle normal C=100", 1'b0, 2'b10, 8'd100, 200);
    duty_case("R8 triangle normal C=1",   1'b0, 2'b10, 8'd1,   2);
    duty_case("R8 triangle normal C=254", 1'b0, 2'b10, 8'd254, 508);
  endtask

  task automatic t_tri_inv();
    duty_case("R9 triangle inverted C=100", 1'b0, 2'b11, 8'd100, 310);
    duty_case("R9 triangle inverted C=30",  1'b0, 2'b11, 8'd30,  450);
  endtask

  task automatic t_tri_ext();
    duty_case("R10 triangle normal C=0",     1'b0, 2'b10, 8'd0,   0);
    duty_case("R10 triangle normal C=255",   1'b0, 2'b10, 8'd255, 510);
    duty_case("R10 triangle inverted C=0",   1'b0, 2'b11, 8'd0,   510);
    duty_case("R10 triangle inverted C=255", 1'b0, 2'b11, 8'd255, 0);
  endtask

  task automatic t_off();
    duty_case("R11 off code 00 wrap",     1'b1, 2'b00, 8'd100, 0);
    duty_case("R11 off code 01 triangle", 1'b0, 2'b01, 8'd0,   0);
    do_reset();
    fast_mode = 1'b1; pol_sel = 2'b10;
    write_duty(8'd255);
    repeat (600) @(negedge clk);
    check("R11 precondition high", pwm_out, 1);
    pol_sel = 2'b01;
    @(negedge clk);
    check("R11 low one clock after off", pwm_out, 0);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_readback();
    t_midwrite();
    t_tick_hold();
    t_fast_norm();
    t_fast_inv();
    t_fast_ext();
    t_tri_norm();
    t_tri_inv();
    t_tri_ext();
    t_off();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule